// File: doc/BRIEF.md
# Dual-Slot Card Status Interrupt Controller

This block watches the status lines of two removable-card slots and turns them into a register view and one interrupt request. Each slot supplies two voltage-sense lines, a write-protect line, two card-detect lines, two battery-condition lines and a ready line. All of them are synchronized to the block clock. Their live levels appear in a pin-status word. Edges on selected lines are latched into a shared change word. A shared enable word selects which change sources may raise the combined interrupt output. Software reaches the registers through a simple 32-bit read/write port with a 2-bit word address.

The two slots share every 32-bit register. Slot A (slot 0) owns bits 31:16, and slot B (slot 1) has the same layout in bits 15:0. Within a half, at offsets 15 down to 4, the fields are: voltage sense 1, voltage sense 2, write protect, detect 2, detect 1, battery 2, battery 1, ready, ready-low, ready-high, ready-rise and ready-fall. Card-detect events pass through a per-slot agreement check and an optional programmable glitch filter. The filter also drives a card-present output for each slot.

Two small state machines shape the behaviour. The start-up sequencer steps through BOOT_FILL1 → BOOT_FILL2 → BOOT_PRIME → BOOT_RUN, one step per clock after reset, and then stays in BOOT_RUN. While the synchronizers fill it blocks edge detection, and in BOOT_PRIME the detect filters adopt the detect levels then on the lines. Each slot's detect filter has the states DET_STABLE and DET_HOLD, with these transitions:
- *start*: DET_STABLE → DET_HOLD, when both detect lines agree on a level that differs from the accepted one and the limit is nonzero.
- *accept*: DET_HOLD → DET_STABLE, when the candidate has held long enough.
- *drop*: DET_HOLD → DET_STABLE, when the lines disagree or change.
- *direct accept*: DET_STABLE → DET_STABLE with a latched event, when the limit is zero.

Top module: `card_stat_irq`

## Requirements
- R1: After reset the change, enable and filter-limit registers are zero and `irq_o` is low. A read of the change word then shows only the live ready-level bits.
- R2: Address 0 returns the synchronized pin levels at offsets 15..8 of each half: vs1, vs2, wp, cd2, cd1, bvd2, bvd1, rdy. Slot A uses bits 31:16, slot B bits 15:0, and the other bits read zero. The voltage-sense pair of slot s reads as a 2-bit field at bit 30-16*s. A pin change becomes visible after two rising edges.
- R3: In the change word (address 1), any edge on wp (offset 13), bvd2 (10) or bvd1 (9) sets its bit. A rising ready sets offset 5 and a falling ready sets offset 4. Each bit is set at the third rising edge after the pin changes.
- R4: Writing a one to a change bit clears it, and writing zero leaves it unchanged. Writes to the level bits, to offsets 15, 14 and 8, and to offsets 3..0 have no effect.
- R5: When a change bit is set by an event in the same cycle that a write clears it, the bit ends up set.
- R6: The enable word (address 2) stores only implemented bits, mask 0x3EF0 in each half. Writing all ones reads back as 0x3EF03EF0.
- R7: `irq_o` is high exactly when some bit of the change view ANDed with the enable word is one. It falls once the enabled sources are cleared or disabled.
- R8: The ready-low bit (offset 7) reads as the inverted synchronized ready level, and ready-high (offset 6) reads as the level itself. Neither can be cleared by a write, so an enabled ready-low keeps `irq_o` high while ready stays low.
- R9: `card_present_o[s]` is one only when both detect lines of slot s have been accepted low. A detect change sets both detect change bits (offsets 12 and 11), and only when both lines agree on the new level.
- R10: The filter limit (address 3, low FILT_W bits, read/write) of zero accepts an agreed detect level at once. A limit L > 0 accepts it only after the lines keep it through L further cycles, so shorter pulses are ignored.
- R11: The pin levels present at the end of reset are adopted without setting any change bit, and the card-present outputs take the detect levels then present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense1_i | input | 2 | Voltage-sense line 1, index = slot |
| sense2_i | input | 2 | Voltage-sense line 2, index = slot |
| wprot_i | input | 2 | Write-protect line, index = slot |
| det2_i | input | 2 | Card-detect line 2 (low = inserted) |
| det1_i | input | 2 | Card-detect line 1 (low = inserted) |
| batt2_i | input | 2 | Battery-condition line 2 |
| batt1_i | input | 2 | Battery-condition line 1 |
| ready_i | input | 2 | Card ready line |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe, taken with `bus_sel_i` |
| bus_addr_i | input | 2 | Word address: 0 pins, 1 change, 2 enable, 3 filter limit |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| card_present_o | output | 2 | Filtered card-present flag per slot |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two functions can meet in one clock: a synchronized edge that sets a change bit, and a software write of one that clears that same bit. The bench provokes this by toggling write protect and placing the one-cycle clear write exactly on the third rising edge after the pin change. It judges the result by reading the bit back as still set, and then shows that the same write alone does clear it. A second overlap is an enabled ready-low level that stays asserted through a clear write; it is judged by `irq_o` staying high until ready returns.

// File: rtl/cstat_pkg.sv
package cstat_pkg;

    localparam int NSLOT  = 2;
    localparam int HALF_W = 16;
    localparam int WORD_W = NSLOT * HALF_W;

    // offsets inside one slot half (the layout is shared by both slots)
    localparam int OFS_WP   = 13;
    localparam int OFS_CD2  = 12;
    localparam int OFS_CD1  = 11;
    localparam int OFS_BVD2 = 10;
    localparam int OFS_BVD1 = 9;
    localparam int OFS_RDYL = 7;
    localparam int OFS_RDYH = 6;
    localparam int OFS_RDYR = 5;
    localparam int OFS_RDYF = 4;

    localparam logic [HALF_W-1:0] EDGE_HALF  = 16'h3E30;
    localparam logic [HALF_W-1:0] LEVEL_HALF = 16'h00C0;
    localparam logic [HALF_W-1:0] IMPL_HALF  = EDGE_HALF | LEVEL_HALF;

    typedef enum logic [1:0] {
        ADR_PINS = 2'd0,
        ADR_CHG  = 2'd1,
        ADR_ENA  = 2'd2,
        ADR_FILT = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        BOOT_FILL1,
        BOOT_FILL2,
        BOOT_PRIME,
        BOOT_RUN
    } boot_state_e;

    typedef enum logic {
        DET_STABLE,
        DET_HOLD
    } det_state_e;

    // one slot's pins, top field first, matching offsets 15..8
    typedef struct packed {
        logic vs1;
        logic vs2;
        logic wp;
        logic cd2;
        logic cd1;
        logic bvd2;
        logic bvd1;
        logic rdy;
    } slot_pins_t;

endpackage

// File: rtl/cstat_sync.sv
module cstat_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;

endmodule

// File: rtl/cstat_det_filter.sv
module cstat_det_filter
    import cstat_pkg::*;
#(
    parameter int FILT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              arm_i,
    input  logic [1:0]        det_i,
    input  logic [FILT_W-1:0] limit_i,
    output logic              present_o,
    output logic              accept_o
);

    det_state_e        state_q, state_d;
    logic              lvl_q, lvl_d;
    logic              cand_q, cand_d;
    logic [FILT_W-1:0] cnt_q, cnt_d;
    logic              accept_d;

    logic agree;
    logic lvl_now;

    assign agree   = (det_i[1] == det_i[0]);
    assign lvl_now = det_i[0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DET_STABLE;
            lvl_q   <= 1'b1;
            cand_q  <= 1'b1;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
            cand_q  <= cand_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        lvl_d    = lvl_q;
        cand_d   = cand_q;
        cnt_d    = cnt_q;
        accept_d = 1'b0;
        if (load_i) begin
            state_d = DET_STABLE;
            lvl_d   = agree ? lvl_now : 1'b1;
            cnt_d   = '0;
        end else if (arm_i) begin
            unique case (state_q)
                DET_STABLE: begin
                    if (agree && (lvl_now != lvl_q)) begin
                        if (limit_i == '0) begin
                            accept_d = 1'b1;
                            lvl_d    = lvl_now;
                        end else begin
                            state_d = DET_HOLD;
                            cand_d  = lvl_now;
                            cnt_d   = {{(FILT_W-1){1'b0}}, 1'b1};
                        end
                    end
                end
                DET_HOLD: begin
                    if (!agree || (lvl_now != cand_q)) begin
                        state_d = DET_STABLE;
                        cnt_d   = '0;
                    end else if (cnt_q >= limit_i) begin
                        accept_d = 1'b1;
                        lvl_d    = cand_q;
                        state_d  = DET_STABLE;
                        cnt_d    = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: state_d = DET_STABLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        present_o = ~lvl_q;
        accept_o  = accept_d;
    end

endmodule

// File: rtl/cstat_slot_events.sv
module cstat_slot_events
    import cstat_pkg::*;
(
    input  logic              arm_i,
    input  logic [3:0]        cur_i,   // {wp, bvd2, bvd1, rdy}
    input  logic [3:0]        prev_i,  // same fields, one cycle older
    input  logic              det_evt_i,
    output logic [HALF_W-1:0] set_o,
    output logic [HALF_W-1:0] level_o
);

    logic [3:0] diff;

    always_comb begin
        diff    = cur_i ^ prev_i;
        set_o   = '0;
        level_o = '0;
        if (arm_i) begin
            set_o[OFS_WP]   = diff[3];
            set_o[OFS_BVD2] = diff[2];
            set_o[OFS_BVD1] = diff[1];
            set_o[OFS_RDYR] = diff[0] &  cur_i[0];
            set_o[OFS_RDYF] = diff[0] & ~cur_i[0];
            set_o[OFS_CD2]  = det_evt_i;
            set_o[OFS_CD1]  = det_evt_i;
        end
        level_o[OFS_RDYL] = ~cur_i[0];
        level_o[OFS_RDYH] =  cur_i[0];
    end

endmodule

// File: rtl/card_stat_irq.sv
module card_stat_irq
    import cstat_pkg::*;
#(
    parameter int FILT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSLOT-1:0]  sense1_i,
    input  logic [NSLOT-1:0]  sense2_i,
    input  logic [NSLOT-1:0]  wprot_i,
    input  logic [NSLOT-1:0]  det2_i,
    input  logic [NSLOT-1:0]  det1_i,
    input  logic [NSLOT-1:0]  batt2_i,
    input  logic [NSLOT-1:0]  batt1_i,
    input  logic [NSLOT-1:0]  ready_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic [NSLOT-1:0]  card_present_o,
    output logic              irq_o
);

    localparam int RAW_W = 8 * NSLOT;
    localparam logic [WORD_W-1:0] EDGE_WORD = {NSLOT{EDGE_HALF}};
    localparam logic [WORD_W-1:0] IMPL_WORD = {NSLOT{IMPL_HALF}};

    logic [RAW_W-1:0]   raw_flat;
    logic [RAW_W-1:0]   syn_flat;
    slot_pins_t         syn   [NSLOT];
    logic [3:0]         prev_q[NSLOT];
    logic [HALF_W-1:0]  set_h [NSLOT];
    logic [HALF_W-1:0]  lvl_h [NSLOT];
    logic [NSLOT-1:0]   det_evt;
    logic [2*NSLOT-1:0] det_pair;

    logic [WORD_W-1:0]  pin_word;
    logic [WORD_W-1:0]  set_word;
    logic [WORD_W-1:0]  lvl_word;
    logic [WORD_W-1:0]  chg_q;
    logic [WORD_W-1:0]  ena_q;
    logic [WORD_W-1:0]  clr_mask;
    logic [WORD_W-1:0]  chg_view;
    logic [FILT_W-1:0]  lim_q;

    boot_state_e boot_q, boot_d;
    logic        arm;
    logic        prime;

    reg_addr_e addr;
    logic      wr_any;

    assign addr   = reg_addr_e'(bus_addr_i);
    assign wr_any = bus_sel_i & bus_wr_i;

    // ---------------- input capture ----------------
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot_in
        assign raw_flat[8*s +: 8] = {sense1_i[s], sense2_i[s], wprot_i[s], det2_i[s],
                                     det1_i[s], batt2_i[s], batt1_i[s], ready_i[s]};
        assign syn[s]             = slot_pins_t'(syn_flat[8*s +: 8]);
        assign det_pair[2*s +: 2] = {syn[s].cd2, syn[s].cd1};
    end

    cstat_sync #(.W(RAW_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_flat),
        .q_o   (syn_flat)
    );

    // ---------------- start-up sequencer ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) boot_q <= BOOT_FILL1;
        else        boot_q <= boot_d;
    end

    always_comb begin
        boot_d = boot_q;
        unique case (boot_q)
            BOOT_FILL1: boot_d = BOOT_FILL2;
            BOOT_FILL2: boot_d = BOOT_PRIME;
            BOOT_PRIME: boot_d = BOOT_RUN;
            BOOT_RUN:   boot_d = BOOT_RUN;
            default:    boot_d = BOOT_FILL1;
        endcase
    end

    always_comb begin
        arm   = (boot_q == BOOT_RUN);
        prime = (boot_q == BOOT_PRIME);
    end

    // ---------------- per-slot event sources ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) prev_q[i] <= '0;
        end else begin
            for (int i = 0; i < NSLOT; i++)
                prev_q[i] <= {syn[i].wp, syn[i].bvd2, syn[i].bvd1, syn[i].rdy};
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        cstat_det_filter #(.FILT_W(FILT_W)) u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (prime),
            .arm_i     (arm),
            .det_i     ({syn[s].cd2, syn[s].cd1}),
            .limit_i   (lim_q),
            .present_o (card_present_o[s]),
            .accept_o  (det_evt[s])
        );

        cstat_slot_events u_evt (
            .arm_i     (arm),
            .cur_i     ({syn[s].wp, syn[s].bvd2, syn[s].bvd1, syn[s].rdy}),
            .prev_i    (prev_q[s]),
            .det_evt_i (det_evt[s]),
            .set_o     (set_h[s]),
            .level_o   (lvl_h[s])
        );
    end

    // slot 0 lands in the upper half, slot 1 in the lower half
    always_comb begin
        pin_word = '0;
        set_word = '0;
        lvl_word = '0;
        for (int i = 0; i < NSLOT; i++) begin
            pin_word[HALF_W*(NSLOT-1-i) +: HALF_W] = {syn[i], 8'h00};
            set_word[HALF_W*(NSLOT-1-i) +: HALF_W] = set_h[i];
            lvl_word[HALF_W*(NSLOT-1-i) +: HALF_W] = lvl_h[i];
        end
    end

    // ---------------- registers ----------------
    assign clr_mask = (wr_any && addr == ADR_CHG) ? (bus_wdata_i & EDGE_WORD) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chg_q <= '0;
            ena_q <= '0;
            lim_q <= '0;
        end else begin
            chg_q <= (chg_q & ~clr_mask) | set_word;
            if (wr_any && addr == ADR_ENA)  ena_q <= bus_wdata_i & IMPL_WORD;
            if (wr_any && addr == ADR_FILT) lim_q <= bus_wdata_i[FILT_W-1:0];
        end
    end

    assign chg_view = chg_q | lvl_word;
    assign irq_o    = |(chg_view & ena_q);

    always_comb begin
        bus_rdata_o = '0;
        unique case (addr)
            ADR_PINS: bus_rdata_o = pin_word;
            ADR_CHG:  bus_rdata_o = chg_view;
            ADR_ENA:  bus_rdata_o = ena_q;
            ADR_FILT: bus_rdata_o = {{(32-FILT_W){1'b0}}, lim_q};
            default:  bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/cstat_chk.sv
module cstat_chk
    import cstat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              irq_o,
    input logic [NSLOT-1:0]  present_i,
    input logic [WORD_W-1:0] chg_i,
    input logic [WORD_W-1:0] ena_i,
    input logic [WORD_W-1:0] set_i,
    input logic [WORD_W-1:0] clr_i,
    input logic [2*NSLOT-1:0] det_i
);

    localparam logic [WORD_W-1:0] EDGE_W = {NSLOT{EDGE_HALF}};
    localparam logic [WORD_W-1:0] IMPL_W = {NSLOT{IMPL_HALF}};

    AST_IRQ_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_o); // R1

    AST_CHG_HOLDS_UNLESS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(chg_i) & ~$past(clr_i)) & ~chg_i) == '0)); // R4

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(set_i) & ~chg_i) == '0)); // R5

    AST_ENA_IMPL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((ena_i & ~IMPL_W) == '0) && ((chg_i & ~EDGE_W) == '0)); // R6

    AST_NO_IRQ_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_i == '0) |-> !irq_o); // R7

    for (genvar s = 0; s < NSLOT; s++) begin : g_pres
        AST_PRESENT_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(present_i[s]) |-> ($past(det_i[2*s +: 2]) == 2'b00)); // R9
    end

endmodule

bind card_stat_irq cstat_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .present_i (card_present_o),
    .chg_i     (chg_q),
    .ena_i     (ena_q),
    .set_i     (set_word),
    .clr_i     (clr_mask),
    .det_i     (det_pair)
);

// File: tb/card_stat_irq_tb.sv
module card_stat_irq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sense1, sense2, wprot, det2, det1, batt2, batt1, ready;
    logic        sel = 1'b0, wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  present;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    card_stat_irq u_dut (
        .clk(clk), .rst_n(rst_n),
        .sense1_i(sense1), .sense2_i(sense2), .wprot_i(wprot),
        .det2_i(det2), .det1_i(det1), .batt2_i(batt2), .batt1_i(batt1), .ready_i(ready),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .card_present_o(present), .irq_o(irq)
    );

    // stimulus A, stimulus B, expected pin word
    localparam logic [47:0] VEC [5] = '{
        {8'h1F, 8'h1F, 32'h1F00_1F00},
        {8'h9F, 8'h5F, 32'h9F00_5F00},
        {8'h3E, 8'h1D, 32'h3E00_1D00},
        {8'h07, 8'h18, 32'h0700_1800},
        {8'hC1, 8'hE2, 32'hC100_E200}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // slot byte order: vs1 vs2 wp cd2 cd1 bvd2 bvd1 rdy
    task automatic set_pins(input logic [7:0] a, input logic [7:0] b);
        {sense1[0], sense2[0], wprot[0], det2[0], det1[0], batt2[0], batt1[0], ready[0]} = a;
        {sense1[1], sense2[1], wprot[1], det2[1], det1[1], batt2[1], batt1[1], ready[1]} = b;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        set_pins(8'h1F, 8'h1F);
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(8);

        // R1 / R11 reset state
        bus_read(2'd1, rd); check("R1 chg after reset", rd, 32'h0040_0040);
        bus_read(2'd2, rd); check("R1 ena after reset", rd, 32'h0);
        bus_read(2'd3, rd); check("R1 limit after reset", rd, 32'h0);
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        check("R11 present after reset", {30'd0, present}, 32'd0);

        // R2 pin-status table
        for (int v = 0; v < 5; v++) begin
            @(negedge clk);
            set_pins(VEC[v][47:40], VEC[v][39:32]);
            repeat (3) @(posedge clk);
            bus_read(2'd0, rd);
            check("R2 pin word", rd, VEC[v][31:0]);
            for (int s = 0; s < 2; s++)
                check("R2 vs field", (rd >> (30 - 16*s)) & 32'h3,
                      {30'd0, (s == 0) ? VEC[v][47:46] : VEC[v][39:38]});
        end
        @(negedge clk);
        set_pins(8'h1F, 8'h1F);
        wait_cyc(6);
        bus_write(2'd1, 32'hFFFF_FFFF);
        bus_read(2'd1, rd); check("R4 clear all", rd, 32'h0040_0040);

        // R3 edge latching with exact latency
        @(negedge clk);
        set_pins(8'h1F, 8'h3F);
        repeat (2) @(posedge clk);
        bus_read(2'd0, rd); check("R2 pin after two edges", rd, 32'h1F00_3F00);
        bus_read(2'd1, rd); check("R3 not yet latched", rd, 32'h0040_0040);
        @(posedge clk);
        bus_read(2'd1, rd); check("R3 wp latched at third edge", rd, 32'h0040_2040);

        @(negedge clk); set_pins(8'h1E, 8'h3F); wait_cyc(4);
        bus_read(2'd1, rd); check("R3 ready fall", rd, 32'h0090_2040);
        @(negedge clk); set_pins(8'h1F, 8'h3F); wait_cyc(4);
        bus_read(2'd1, rd); check("R3 ready rise", rd, 32'h0070_2040);
        @(negedge clk); set_pins(8'h1D, 8'h3B); wait_cyc(4);
        bus_read(2'd1, rd); check("R3 battery edges", rd, 32'h0270_2440);

        // R4 write-one-to-clear
        bus_write(2'd1, 32'h0);
        bus_read(2'd1, rd); check("R4 zero write keeps", rd, 32'h0270_2440);
        bus_write(2'd1, 32'h0010_0000);
        bus_read(2'd1, rd); check("R4 single clear", rd, 32'h0260_2440);
        bus_write(2'd1, 32'h00C0_00C0);
        bus_read(2'd1, rd); check("R8 level bits ignore write", rd, 32'h0260_2440);
        bus_write(2'd1, 32'hFFFF_FFFF);
        bus_read(2'd1, rd); check("R4 clear all again", rd, 32'h0040_0040);

        // R5 set and clear in the same cycle
        @(negedge clk); set_pins(8'h1D, 8'h1B); wait_cyc(4);
        bus_write(2'd1, 32'h0000_2000);
        @(negedge clk);
        set_pins(8'h1D, 8'h3B);
        repeat (2) @(posedge clk);
        bus_write(2'd1, 32'h0000_2000);   // write lands on the third edge
        bus_read(2'd1, rd); check("R5 set wins over clear", rd, 32'h0040_2040);
        bus_write(2'd1, 32'h0000_2000);
        bus_read(2'd1, rd); check("R5 clear alone", rd, 32'h0040_0040);

        // R6 / R7 enable and interrupt
        bus_write(2'd2, 32'hFFFF_FFFF);
        bus_read(2'd2, rd); check("R6 enable mask", rd, 32'h3EF0_3EF0);
        check("R7 irq from enabled level bit", {31'd0, irq}, 32'd1);
        bus_write(2'd2, 32'h0);
        check("R7 irq masked", {31'd0, irq}, 32'd0);
        bus_write(2'd2, 32'h0000_2000);
        check("R7 irq idle", {31'd0, irq}, 32'd0);
        @(negedge clk); set_pins(8'h1D, 8'h1B); wait_cyc(4);
        check("R7 irq on wp edge", {31'd0, irq}, 32'd1);
        bus_write(2'd1, 32'h0000_2000);
        check("R7 irq after clear", {31'd0, irq}, 32'd0);

        // R8 ready-low is a level source
        bus_write(2'd2, 32'h0080_0000);
        @(negedge clk); set_pins(8'h1C, 8'h1B); wait_cyc(4);
        check("R8 irq while ready low", {31'd0, irq}, 32'd1);
        bus_write(2'd1, 32'h0080_0000);
        check("R8 irq survives clear", {31'd0, irq}, 32'd1);
        bus_read(2'd1, rd); check("R8 ready-low bit", rd & 32'h00C0_0000, 32'h0080_0000);
        @(negedge clk); set_pins(8'h1D, 8'h1B); wait_cyc(3);
        check("R8 irq after ready high", {31'd0, irq}, 32'd0);
        bus_write(2'd2, 32'h0);
        bus_write(2'd1, 32'hFFFF_FFFF);

        // R9 detect agreement
        @(negedge clk); set_pins(8'h15, 8'h1B); wait_cyc(6);
        check("R9 one line low not present", {30'd0, present}, 32'd0);
        bus_read(2'd1, rd); check("R9 no detect event", rd & 32'h1800_0000, 32'h0);
        @(negedge clk); set_pins(8'h05, 8'h1B); wait_cyc(6);
        check("R9 both low present", {30'd0, present}, 32'd1);
        bus_read(2'd1, rd); check("R9 detect event", rd & 32'h1800_0000, 32'h1800_0000);
        @(negedge clk); set_pins(8'h1D, 8'h03); wait_cyc(6);
        check("R9 slot B present", {30'd0, present}, 32'd2);
        @(negedge clk); set_pins(8'h1D, 8'h1B); wait_cyc(6);
        bus_write(2'd1, 32'hFFFF_FFFF);

        // R10 glitch filter
        bus_write(2'd3, 32'd10);
        bus_read(2'd3, rd); check("R10 limit readback", rd, 32'd10);
        @(negedge clk); set_pins(8'h05, 8'h1B); wait_cyc(5);
        set_pins(8'h1D, 8'h1B); wait_cyc(20);
        check("R10 short pulse ignored", {30'd0, present}, 32'd0);
        bus_read(2'd1, rd); check("R10 no event on pulse", rd & 32'h1800_0000, 32'h0);
        set_pins(8'h05, 8'h1B); wait_cyc(8);
        check("R10 still holding", {30'd0, present}, 32'd0);
        wait_cyc(22);
        check("R10 accepted after hold", {30'd0, present}, 32'd1);
        bus_read(2'd1, rd); check("R10 event after hold", rd & 32'h1800_0000, 32'h1800_0000);
        set_pins(8'h1D, 8'h1B); wait_cyc(30);
        bus_write(2'd3, 32'd0);

        // R11 start-up values adopted without events
        @(negedge clk);
        rst_n = 1'b0;
        set_pins(8'h27, 8'h1B);
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(8);
        bus_read(2'd1, rd); check("R11 no events from start-up", rd, 32'h0040_0040);
        check("R11 present adopted", {30'd0, present}, 32'd1);
        check("R1 irq low after second reset", {31'd0, irq}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule